// File: doc/BRIEF.md
# Configurable Parallel CRC Engine

This block keeps a CRC remainder in one register and, on every clock where a word is valid, folds a whole data word of `DATA_W` bits into it. The generator polynomial, its width (1 to 64 bits), the data width, the seed source, the bit order within each byte, the byte order within the word and the output inversion pattern are all elaboration-time parameters. Any polynomial value can be used, so the same block covers the common standards and custom codes.

A start pulse reloads the seed and opens a new frame. When the optional run/shift pin is included, driving it low turns the remainder register into a plain right shifter. The finished remainder then leaves one bit per clock on a serial pin, least significant bit first. The CRC output is the register XORed with the selected constant mask, so it needs no logic beyond one XOR level. Framing the result into a transmitted stream is the user's job.

Top module: `crc_fold_engine`

## Requirements
- R1: Each clock with `valid_i` high, `start_i` low and the block in run mode, the register takes the remainder of all `DATA_W` input bits, one after another, as a single-bit CRC with polynomial `POLY[POLY_W-1:0]` would produce. The implicit top coefficient is left out. Any polynomial width from 1 to 64 is allowed.
- R2: `SEED_MODE` picks the seed. 0 gives all zeros, 1 gives all ones and 2 gives the value on `seed_i`. The seed is loaded into the register in any cycle where `rst` or `start_i` is high.
- R3: `start_i` takes priority over `valid_i` and over shift mode in the same cycle.
- R4: In run mode with `valid_i` low, the register keeps its value.
- R5: With `LSB_FIRST`=0, bit 7 of each byte enters first and the register shifts toward its MSB, with feedback from bit `POLY_W-1`. With `LSB_FIRST`=1, bit 0 of each byte enters first, the register is held in reflected form and shifts toward bit 0, with feedback from bit 0 and the bit-reversed polynomial.
- R6: With `LOW_BYTE_FIRST`=1, byte 0 (`data_i[7:0]`) is folded first. With 0, the top byte is folded first.
- R7: `crc_o` is the register XOR a mask chosen by `XOR_MODE`. 0 gives no mask, 1 gives all ones, 2 sets the odd-numbered bits (…1010) and 3 sets the even-numbered bits (…0101).
- R8: With `HAS_SHIFT`=1 and `run_i` low, the register shifts right by one bit per clock with zero entering the MSB, whatever `valid_i` is. `ser_o` always shows register bit 0.
- R9: With `HAS_SHIFT`=0, `run_i` has no effect and the block always computes.
- R10: Set up as CRC-32 (polynomial 0x04C11DB7, `LSB_FIRST`=1, all-ones seed, `XOR_MODE`=1, 8-bit data), the block gives 0xCBF43926 on `crc_o` after the ASCII bytes "123456789".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, loads the seed |
| start_i | input | 1 | Start of frame, loads the seed |
| valid_i | input | 1 | Data word valid in this cycle |
| data_i | input | DATA_W | Data word to fold |
| seed_i | input | POLY_W | Seed value, used when `SEED_MODE`=2 |
| run_i | input | 1 | High: CRC mode. Low: shift mode (only when `HAS_SHIFT`=1) |
| crc_o | output | POLY_W | Register XOR output mask |
| ser_o | output | 1 | Register bit 0, serial shift-out |

## Verification
The assertions check on every cycle the behaviour that needs no polynomial arithmetic. This covers seed loading after a start pulse, priority of start, holding while idle in run mode, the one-bit right shift with zero fill, and `ser_o` tracking the unmasked bit 0 of the register. The actual remainder values depend on polynomial, bit order and byte order, so only the bench's scenarios can show them. The bench compares three differently configured instances against a bitwise model each clock and checks the CRC-32 check value and the serial readout of the finished remainder.

// File: rtl/crc_fold_pkg.sv
package crc_fold_pkg;

  localparam int SEED_ZERO = 0;
  localparam int SEED_ONES = 1;
  localparam int SEED_PORT = 2;

  localparam int MASK_NONE = 0;
  localparam int MASK_ALL  = 1;
  localparam int MASK_ODD  = 2;
  localparam int MASK_EVEN = 3;

  // Reverse the low w bits of v; upper bits are cleared.
  function automatic logic [63:0] rev_low(input logic [63:0] v, input int w);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < w) r[i] = v[w-1-i];
    end
    return r;
  endfunction

  // Constant output mask for the chosen mode, limited to w bits.
  function automatic logic [63:0] out_mask(input int mode, input int w);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < w) begin
        case (mode)
          MASK_ALL:  m[i] = 1'b1;
          MASK_ODD:  m[i] = ((i % 2) == 1);
          MASK_EVEN: m[i] = ((i % 2) == 0);
          default:   m[i] = 1'b0;
        endcase
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/crc_bit_step.sv
// One serial CRC step: folds a single input bit into the remainder.
module crc_bit_step #(
  parameter int              W         = 32,
  parameter bit              LSB_FIRST = 1'b1,
  parameter logic [W-1:0]    TAPS      = '0
) (
  input  logic [W-1:0] cur,
  input  logic         bit_i,
  output logic [W-1:0] nxt
);

  logic fb;

  generate
    if (LSB_FIRST) begin : g_refl
      assign fb  = cur[0] ^ bit_i;
      assign nxt = (cur >> 1) ^ (fb ? TAPS : '0);
    end else begin : g_norm
      assign fb  = cur[W-1] ^ bit_i;
      assign nxt = (cur << 1) ^ (fb ? TAPS : '0);
    end
  endgenerate

endmodule

// File: rtl/crc_word_order.sv
// Reorders a data word into the serial order in which bits enter the CRC:
// seq[0] is folded first.
module crc_word_order #(
  parameter int DATA_W         = 8,
  parameter bit LSB_FIRST      = 1'b1,
  parameter bit LOW_BYTE_FIRST = 1'b1
) (
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] seq
);

  localparam int NB = DATA_W / 8;

  generate
    for (genvar k = 0; k < NB; k++) begin : g_byte
      localparam int SRC_BYTE = LOW_BYTE_FIRST ? k : (NB - 1 - k);
      for (genvar j = 0; j < 8; j++) begin : g_bit
        localparam int SRC_BIT = LSB_FIRST ? j : (7 - j);
        assign seq[k*8 + j] = data[SRC_BYTE*8 + SRC_BIT];
      end
    end
  endgenerate

endmodule

// File: rtl/crc_word_fold.sv
// Unrolled chain of DATA_W single-bit steps.
module crc_word_fold
  import crc_fold_pkg::*;
#(
  parameter int          W         = 32,
  parameter logic [63:0] POLY      = 64'h04C11DB7,
  parameter int          DATA_W    = 8,
  parameter bit          LSB_FIRST = 1'b1
) (
  input  logic [W-1:0]      cur,
  input  logic [DATA_W-1:0] seq,
  output logic [W-1:0]      nxt
);

  localparam logic [63:0] TAPS64 = LSB_FIRST ? rev_low(POLY, W) : POLY;
  localparam logic [W-1:0] TAPS  = TAPS64[W-1:0];

  logic [W-1:0] stage [DATA_W+1];

  assign stage[0] = cur;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_step
      crc_bit_step #(
        .W(W), .LSB_FIRST(LSB_FIRST), .TAPS(TAPS)
      ) u_step (
        .cur(stage[i]), .bit_i(seq[i]), .nxt(stage[i+1])
      );
    end
  endgenerate

  assign nxt = stage[DATA_W];

endmodule

// File: rtl/crc_fold_engine.sv
module crc_fold_engine
  import crc_fold_pkg::*;
#(
  parameter int          POLY_W         = 32,
  parameter logic [63:0] POLY           = 64'h04C11DB7,
  parameter int          DATA_W         = 8,
  parameter int          SEED_MODE      = 2,
  parameter bit          LSB_FIRST      = 1'b1,
  parameter bit          LOW_BYTE_FIRST = 1'b1,
  parameter int          XOR_MODE       = 1,
  parameter bit          HAS_SHIFT      = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [POLY_W-1:0] seed_i,
  input  logic              run_i,
  output logic [POLY_W-1:0] crc_o,
  output logic              ser_o
);

  localparam logic [63:0]       MASK64 = out_mask(XOR_MODE, POLY_W);
  localparam logic [POLY_W-1:0] MASK   = MASK64[POLY_W-1:0];

  logic [POLY_W-1:0] crc_q;
  logic [POLY_W-1:0] seed_v;
  logic [POLY_W-1:0] folded;
  logic [DATA_W-1:0] seq;
  logic              shift_sel;

  generate
    if (SEED_MODE == SEED_PORT) begin : g_seed_port
      assign seed_v = seed_i;
    end else if (SEED_MODE == SEED_ONES) begin : g_seed_ones
      assign seed_v = '1;
    end else begin : g_seed_zero
      assign seed_v = '0;
    end

    if (HAS_SHIFT) begin : g_shift
      assign shift_sel = ~run_i;
    end else begin : g_noshift
      assign shift_sel = 1'b0;
    end
  endgenerate

  crc_word_order #(
    .DATA_W(DATA_W), .LSB_FIRST(LSB_FIRST), .LOW_BYTE_FIRST(LOW_BYTE_FIRST)
  ) u_order (
    .data(data_i), .seq(seq)
  );

  crc_word_fold #(
    .W(POLY_W), .POLY(POLY), .DATA_W(DATA_W), .LSB_FIRST(LSB_FIRST)
  ) u_fold (
    .cur(crc_q), .seq(seq), .nxt(folded)
  );

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      crc_q <= seed_v;
    end else if (shift_sel) begin
      crc_q <= crc_q >> 1;
    end else if (valid_i) begin
      crc_q <= folded;
    end
  end

  assign crc_o = crc_q ^ MASK;
  assign ser_o = crc_q[0];

endmodule

// File: rtl/crc_fold_checker.sv
module crc_fold_checker
  import crc_fold_pkg::*;
#(
  parameter int POLY_W    = 32,
  parameter int SEED_MODE = 2,
  parameter int XOR_MODE  = 1,
  parameter bit HAS_SHIFT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              valid_i,
  input logic [POLY_W-1:0] seed_i,
  input logic              run_i,
  input logic [POLY_W-1:0] crc_o,
  input logic              ser_o
);

  localparam logic [63:0]       M64 = out_mask(XOR_MODE, POLY_W);
  localparam logic [POLY_W-1:0] M   = M64[POLY_W-1:0];

  logic [POLY_W-1:0] raw;
  logic [POLY_W-1:0] exp_seed;
  logic              in_shift;

  assign raw      = crc_o ^ M;
  assign exp_seed = (SEED_MODE == SEED_PORT) ? seed_i :
                    (SEED_MODE == SEED_ONES) ? '1 : '0;
  assign in_shift = HAS_SHIFT && !run_i;

  // R2 / R3: start loads the seed regardless of valid or shift mode
  p_seed_load_r2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> raw == $past(exp_seed));

  // R3: start wins over a simultaneous valid word
  p_start_first_r3: assert property (@(posedge clk) disable iff (rst)
    (start_i && valid_i) |=> raw == $past(exp_seed));

  // R4 / R9: idle in run mode holds the output
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !valid_i && !in_shift) |=> $stable(crc_o));

  // R8: shift mode moves the register right with zero fill
  p_shift_right_r8: assert property (@(posedge clk) disable iff (rst)
    (!start_i && in_shift) |=> raw == ($past(raw) >> 1));

  // R8: serial pin shows register bit 0
  p_serial_lsb_r8: assert property (@(posedge clk) disable iff (rst)
    ser_o == raw[0]);

endmodule

bind crc_fold_engine crc_fold_checker #(
  .POLY_W(POLY_W), .SEED_MODE(SEED_MODE), .XOR_MODE(XOR_MODE), .HAS_SHIFT(HAS_SHIFT)
) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .valid_i(valid_i),
  .seed_i(seed_i), .run_i(run_i), .crc_o(crc_o), .ser_o(ser_o)
);

// File: tb/crc_fold_engine_test.sv
module crc_fold_engine_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, start, valid, run;
  logic [63:0] data, seed;
  logic [31:0] crc_a;  logic ser_a;
  logic [15:0] crc_b;  logic ser_b;
  logic [4:0]  crc_c;  logic ser_c;

  int checks = 0, fails = 0;
  string tag = "R2";

  // A: CRC-32, reflected, ones seed, all inverted, shift pin present
  crc_fold_engine #(.POLY_W(32), .POLY(64'h04C11DB7), .DATA_W(8), .SEED_MODE(1),
    .LSB_FIRST(1'b1), .LOW_BYTE_FIRST(1'b1), .XOR_MODE(1), .HAS_SHIFT(1'b1)) uut (
    .clk(clk), .rst(rst), .start_i(start), .valid_i(valid), .data_i(data[7:0]),
    .seed_i(seed[31:0]), .run_i(run), .crc_o(crc_a), .ser_o(ser_a));

  // B: 16-bit, MSB-first, low byte first, port seed, odd mask, no shift pin
  crc_fold_engine #(.POLY_W(16), .POLY(64'h1021), .DATA_W(16), .SEED_MODE(2),
    .LSB_FIRST(1'b0), .LOW_BYTE_FIRST(1'b1), .XOR_MODE(2), .HAS_SHIFT(1'b0)) uut_b (
    .clk(clk), .rst(rst), .start_i(start), .valid_i(valid), .data_i(data[15:0]),
    .seed_i(seed[15:0]), .run_i(run), .crc_o(crc_b), .ser_o(ser_b));

  // C: 5-bit, LSB-first, high byte first, zero seed, even mask, shift pin
  crc_fold_engine #(.POLY_W(5), .POLY(64'h15), .DATA_W(24), .SEED_MODE(0),
    .LSB_FIRST(1'b1), .LOW_BYTE_FIRST(1'b0), .XOR_MODE(3), .HAS_SHIFT(1'b1)) uut_c (
    .clk(clk), .rst(rst), .start_i(start), .valid_i(valid), .data_i(data[23:0]),
    .seed_i(seed[4:0]), .run_i(run), .crc_o(crc_c), .ser_o(ser_c));

  logic [63:0] ma, mb, mc;

  function automatic logic [63:0] wmask(int w);
    return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] xmask(int mode, int w);
    logic [63:0] m = '0;
    for (int i = 0; i < w; i++)
      m[i] = (mode == 1) || (mode == 2 && i % 2 == 1) || (mode == 3 && i % 2 == 0);
    return m;
  endfunction

  function automatic logic [63:0] fold(logic [63:0] r, logic [63:0] d, int w,
      logic [63:0] p, int dw, bit lsb, bit lowfirst);
    logic [63:0] rp = '0;
    int nb = dw / 8;
    for (int i = 0; i < w; i++) rp[w-1-i] = p[i];
    for (int k = 0; k < nb; k++) begin
      int by = lowfirst ? k : nb - 1 - k;
      for (int j = 0; j < 8; j++) begin
        logic b, fb;
        b = d[by*8 + (lsb ? j : 7 - j)];
        if (lsb) begin
          fb = r[0] ^ b;  r = r >> 1;  if (fb) r = r ^ rp;
        end else begin
          fb = r[w-1] ^ b;  r = (r << 1) & wmask(w);  if (fb) r = r ^ (p & wmask(w));
        end
      end
    end
    return r & wmask(w);
  endfunction

  task automatic check(string req, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Apply inputs for one clock, advance the model, then compare all outputs.
  task automatic cyc(bit r, bit s, bit v, bit rn, logic [63:0] d);
    rst = r; start = s; valid = v; run = rn; data = d;
    if (r || s) begin
      ma = 64'hFFFF_FFFF; mb = seed & wmask(16); mc = '0;
    end else begin
      if (!rn) ma = ma >> 1; else if (v) ma = fold(ma, d, 32, 64'h04C11DB7, 8, 1, 1);
      if (v) mb = fold(mb, d, 16, 64'h1021, 16, 0, 1);
      if (!rn) mc = mc >> 1; else if (v) mc = fold(mc, d, 5, 64'h15, 24, 1, 0);
    end
    @(negedge clk);
    check(tag, "A crc", {32'h0, crc_a}, ma ^ xmask(1, 32));
    check(tag, "B crc", {48'h0, crc_b}, mb ^ xmask(2, 16));
    check(tag, "C crc", {59'h0, crc_c}, mc ^ xmask(3, 5));
    check(tag, "A ser", {63'h0, ser_a}, {63'h0, ma[0]});
    check(tag, "B ser", {63'h0, ser_b}, {63'h0, mb[0]});
    check(tag, "C ser", {63'h0, ser_c}, {63'h0, mc[0]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    string msg = "123456789";
    logic [31:0] outbits;
    logic [31:0] held;
    rst = 1; start = 0; valid = 0; run = 1; data = '0;
    seed = 64'h0000_0000_0000_BEEF;
    @(negedge clk);

    // R2: reset loads each instance's seed
    tag = "R2";
    cyc(1, 0, 0, 1, '0);
    cyc(1, 0, 1, 0, 64'h55);
    check("R2", "A reset crc", {32'h0, crc_a}, 64'h0);
    check("R2", "B port seed", {48'h0, crc_b}, 64'hBEEF ^ 64'hAAAA);

    // R10: standard check value
    tag = "R10";
    cyc(0, 1, 0, 1, '0);
    for (int i = 0; i < 9; i++) cyc(0, 0, 1, 1, {56'h0, msg[i]});
    check("R10", "CRC-32 check value", {32'h0, crc_a}, 64'hCBF43926);

    // R4: idle in run mode holds
    tag = "R4";
    held = crc_a;
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 64'hDEAD_BEEF_1234_5678);
    check("R4", "A held", {32'h0, crc_a}, {32'h0, held});

    // R8 / R9: shift out the unmasked remainder LSB first; B keeps computing
    tag = "R8/R9";
    for (int k = 0; k < 32; k++) begin
      outbits[k] = ser_a;
      cyc(0, 0, 1, 0, {48'h0, 16'(k * 16'h1357)});
    end
    check("R8", "A serial readout", {32'h0, outbits}, 64'h340BC6D9);
    check("R8", "A empty after 32 shifts", {32'h0, crc_a}, 64'hFFFF_FFFF);

    // R3: start beats valid and shift mode
    tag = "R3";
    seed = 64'h0000_0000_0000_1234;
    cyc(0, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R3", "B start over valid", {48'h0, crc_b}, 64'h1234 ^ 64'hAAAA);
    check("R3", "A start over shift", {32'h0, crc_a}, 64'h0);

    // R1 / R5 / R6 / R7: random traffic, model compare each clock
    tag = "R1/R5/R6/R7";
    for (int n = 0; n < 3000; n++) begin
      seed = {$urandom, $urandom};
      cyc(0, ($urandom % 60) == 0, ($urandom % 4) != 0, ($urandom % 12) != 0,
          {$urandom, $urandom});
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule